// File: doc/BRIEF.md
# I2C Byte-Memory Slave with Deferred Write

This block is the serial front end of a small byte-addressed memory. The memory is modelled as an on-chip register array. The block follows the two bus wires with a fast system clock. It detects start and stop conditions, decodes the device byte against three strap pins, and acknowledges the bytes of a byte write: device byte, byte address and data. The received byte is not stored at once. It waits in a holding register until the master issues a stop. Only then does the block write it into the array and start an emulated internal write cycle of fixed length. For that whole time the block takes no notice of the bus.

The strap field in the device byte has two uses, chosen by a memory-size input. For small sizes it selects the device. For larger sizes its lower positions supply the upper array address bits. A random read returns the stored byte so that writes can be checked. The read is a byte-address write, a repeated start, and a device byte with the direction bit set.

Top module: `i2c_mem_slave`

## Requirements
- R1: While reset is held, and after it is released with an idle bus, `busy_o` and `sda_oe_o` are both 0.
- R2: The device byte is sent MSB first. Bits 7:4 must equal 1010. Bits 3:1 are the strap field S2,S1,S0 and bit 0 is the direction (1 = read). With `mem_size_i` = 0 (1 Kbit) or 1 (2 Kbit), all of S2..S0 must equal `dev_sel_i[2:0]`. The block pulls SDA low (`sda_oe_o` = 1) during the ninth SCL clock only when the byte is accepted. Otherwise it stays silent for the rest of the transfer.
- R3: After an accepted device byte with bit 0 = 0, the block acknowledges the byte address and then the data byte, each in its ninth clock.
- R4: With `mem_size_i` = 2 (4 Kbit), only S2,S1 are compared. S0 becomes array address bit 8.
- R5: With `mem_size_i` = 3 (8 Kbit), only S2 is compared. S0 becomes address bit 8 and S1 becomes address bit 9.
- R6: The held data byte is written into the array on the stop that follows its acknowledge. `busy_o` then goes high and stays high for exactly `WR_CYCLES` system clocks.
- R7: If a start arrives instead of that stop, the held byte is discarded and the array is unchanged.
- R8: A read returns the byte at the address formed from the latched byte address and the upper bits of the read's device byte, MSB first. The block releases SDA after the eighth data bit.
- R9: A stop that arrives in the middle of the data byte ends the transaction without a write.
- R10: While `busy_o` is high, no byte is acknowledged and no bus activity changes the array.
- R11: With `mem_size_i` = 0, byte address bit 7 is ignored, so the array holds 128 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| dev_sel_i | input | 3 | Strap pins compared against the device byte |
| mem_size_i | input | 2 | 0 = 1 Kbit, 1 = 2 Kbit, 2 = 4 Kbit, 3 = 8 Kbit |
| busy_o | output | 1 | High during the internal write cycle |

## Verification
Two functions meet in the same cycle: the commit of a held byte on stop, and the lockout that follows it. The bench issues a new start within a few clocks of the committing stop. It then sends a full write of a different byte while `busy_o` is still high. The result is judged in three ways: no acknowledge appears on the line, the busy window keeps its exact length, and later reads return only the byte from before the stop. A second collision is a start or stop that lands where a write would otherwise commit. That is a repeated start straight after the data acknowledge, or a stop after four data bits. Both are judged by reading the location back unchanged and by counting no extra busy windows.

// File: rtl/i2c_mem_pkg.sv
package i2c_mem_pkg;
  localparam logic [3:0] DEV_PREFIX = 4'b1010;

  localparam logic [1:0] SZ_1K = 2'd0;
  localparam logic [1:0] SZ_2K = 2'd1;
  localparam logic [1:0] SZ_4K = 2'd2;
  localparam logic [1:0] SZ_8K = 2'd3;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_BADR,
    ST_BADR_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_HOLD,
    ST_RDAT,
    ST_BUSY
  } link_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw;
  logic [NLINES-1:0] cur;
  logic [NLINES-1:0] prv;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [STAGES-1:0] pipe;
    logic              last;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pipe <= '1;
        last <= 1'b1;
      end else begin
        pipe <= {pipe[STAGES-2:0], raw[g]};
        last <= pipe[STAGES-1];
      end
    end
    assign cur[g] = pipe[STAGES-1];
    assign prv[g] = last;
  end

  logic scl_s, scl_q, sda_s, sda_q;
  assign scl_s = cur[1];
  assign scl_q = prv[1];
  assign sda_s = cur[0];
  assign sda_q = prv[0];

  assign sda_s_o    = sda_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  // data edges while clock stays high
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_dev_decode.sv
module i2c_dev_decode
  import i2c_mem_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic [6:0]        dev_bits_i,  // device byte bits 7:1
  input  logic [2:0]        dev_sel_i,
  input  logic [1:0]        mem_size_i,
  input  logic [1:0]        upper_q_i,
  input  logic [7:0]        badr_i,
  output logic              match_o,
  output logic [1:0]        upper_o,
  output logic [ADDR_W-1:0] mem_addr_o
);
  logic [2:0] strap;
  logic       prefix_ok;
  logic       strap_ok;

  assign strap     = dev_bits_i[2:0];
  assign prefix_ok = (dev_bits_i[6:3] == DEV_PREFIX);

  always_comb begin
    strap_ok = 1'b0;
    upper_o  = 2'b00;
    unique case (mem_size_i)
      SZ_1K, SZ_2K: strap_ok = (strap == dev_sel_i);
      SZ_4K: begin
        strap_ok = (strap[2:1] == dev_sel_i[2:1]);
        upper_o  = {1'b0, strap[0]};
      end
      default: begin
        strap_ok = (strap[2] == dev_sel_i[2]);
        upper_o  = strap[1:0];
      end
    endcase
  end

  assign match_o = prefix_ok & strap_ok;

  always_comb begin
    mem_addr_o = '0;
    unique case (mem_size_i)
      SZ_1K:   mem_addr_o[6:0] = badr_i[6:0];
      SZ_2K:   mem_addr_o[7:0] = badr_i;
      SZ_4K:   mem_addr_o[8:0] = {upper_q_i[0], badr_i};
      default: mem_addr_o[9:0] = {upper_q_i, badr_i};
    endcase
  end
endmodule

// File: rtl/i2c_mem_array.sv
module i2c_mem_array #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (we_i) begin
      cells[addr_i] <= wdata_i;
    end
  end

  assign rdata_o = cells[addr_i];
endmodule

// File: rtl/i2c_link_fsm.sv
module i2c_link_fsm
  import i2c_mem_pkg::*;
#(
  parameter int WR_CYCLES = 1000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sda_s_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       match_i,
  input  logic [1:0] upper_i,
  input  logic [7:0] rdata_i,
  output logic [6:0] dev_bits_o,
  output logic [1:0] upper_q_o,
  output logic [7:0] badr_o,
  output logic [7:0] wdata_o,
  output logic       we_o,
  output logic       sda_oe_o,
  output logic       busy_o
);
  localparam int CNT_W = $clog2(WR_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WR_CYCLES - 1);

  link_state_e state;
  logic [3:0]  bit_cnt;
  logic [7:0]  shreg;
  logic        rw_q;
  logic [1:0]  upper_q;
  logic [7:0]  badr_q;
  logic [7:0]  wdat_q;
  logic [CNT_W-1:0] wait_cnt;
  logic        oe_q;

  logic rx_state;
  assign rx_state = (state == ST_DEV) || (state == ST_BADR) || (state == ST_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      rw_q     <= 1'b0;
      upper_q  <= '0;
      badr_q   <= '0;
      wdat_q   <= '0;
      wait_cnt <= '0;
      oe_q     <= 1'b0;
    end else if (state == ST_BUSY) begin
      // bus is ignored until the write cycle ends
      if (wait_cnt == '0) state <= ST_IDLE;
      else                wait_cnt <= wait_cnt - 1'b1;
    end else if (start_i) begin
      state   <= ST_DEV;
      bit_cnt <= '0;
      oe_q    <= 1'b0;
    end else if (stop_i) begin
      oe_q <= 1'b0;
      if (state == ST_HOLD) begin
        state    <= ST_BUSY;
        wait_cnt <= CNT_LOAD;
      end else begin
        state <= ST_IDLE;
      end
    end else begin
      if (rx_state && scl_rise_i) begin
        shreg   <= {shreg[6:0], sda_s_i};
        bit_cnt <= bit_cnt + 1'b1;
      end
      if (rx_state && scl_fall_i && bit_cnt == 4'd8) begin
        bit_cnt <= '0;
        unique case (state)
          ST_DEV: begin
            if (match_i) begin
              rw_q    <= shreg[0];
              upper_q <= upper_i;
              oe_q    <= 1'b1;
              state   <= ST_DEV_ACK;
            end else begin
              state <= ST_IDLE;
            end
          end
          ST_BADR: begin
            badr_q <= shreg;
            oe_q   <= 1'b1;
            state  <= ST_BADR_ACK;
          end
          default: begin
            wdat_q <= shreg;
            oe_q   <= 1'b1;
            state  <= ST_DATA_ACK;
          end
        endcase
      end
      if (scl_fall_i) begin
        unique case (state)
          ST_DEV_ACK: begin
            bit_cnt <= '0;
            if (rw_q) begin
              shreg   <= rdata_i;
              oe_q    <= ~rdata_i[7];
              bit_cnt <= 4'd1;
              state   <= ST_RDAT;
            end else begin
              oe_q  <= 1'b0;
              state <= ST_BADR;
            end
          end
          ST_BADR_ACK: begin
            oe_q  <= 1'b0;
            state <= ST_DATA;
          end
          ST_DATA_ACK: begin
            oe_q  <= 1'b0;
            state <= ST_HOLD;
          end
          ST_RDAT: begin
            if (bit_cnt == 4'd8) begin
              oe_q  <= 1'b0;
              state <= ST_IDLE;
            end else begin
              oe_q    <= ~shreg[6];
              shreg   <= {shreg[6:0], 1'b0};
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign dev_bits_o = shreg[7:1];
  assign upper_q_o  = upper_q;
  assign badr_o     = badr_q;
  assign wdata_o    = wdat_q;
  assign we_o       = stop_i && (state == ST_HOLD);
  assign sda_oe_o   = oe_q;
  assign busy_o     = (state == ST_BUSY);
endmodule

// File: rtl/i2c_mem_slave.sv
module i2c_mem_slave #(
  parameter int WR_CYCLES   = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [2:0] dev_sel_i,
  input  logic [1:0] mem_size_i,
  output logic       busy_o
);
  localparam int ADDR_W = 10;
  localparam int DATA_W = 8;

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [6:0] dev_bits;
  logic [1:0] upper, upper_q;
  logic [7:0] badr;
  logic [DATA_W-1:0] wdata, rdata;
  logic       match, mem_we;
  logic [ADDR_W-1:0] mem_addr;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .sda_s_o    (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  i2c_dev_decode #(.ADDR_W(ADDR_W)) u_dec (
    .dev_bits_i (dev_bits),
    .dev_sel_i  (dev_sel_i),
    .mem_size_i (mem_size_i),
    .upper_q_i  (upper_q),
    .badr_i     (badr),
    .match_o    (match),
    .upper_o    (upper),
    .mem_addr_o (mem_addr)
  );

  i2c_link_fsm #(.WR_CYCLES(WR_CYCLES)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sda_s_i    (sda_s),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .match_i    (match),
    .upper_i    (upper),
    .rdata_i    (rdata),
    .dev_bits_o (dev_bits),
    .upper_q_o  (upper_q),
    .badr_o     (badr),
    .wdata_o    (wdata),
    .we_o       (mem_we),
    .sda_oe_o   (sda_oe_o),
    .busy_o     (busy_o)
  );

  i2c_mem_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mem_we),
    .addr_i  (mem_addr),
    .wdata_i (wdata),
    .rdata_o (rdata)
  );
endmodule

// File: rtl/i2c_mem_slave_chk.sv
module i2c_mem_slave_chk #(
  parameter int WR_CYCLES = 1000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic busy_o,
  input logic sda_oe_o,
  input logic scl_fall,
  input logic stop_det,
  input logic mem_we
);
  int run_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     run_cnt <= 0;
    else if (busy_o) run_cnt <= run_cnt + 1;
    else             run_cnt <= 0;
  end

  // R10
  busy_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !sda_oe_o);

  // R10
  busy_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !mem_we);

  // R2
  oe_on_low_clk_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> $past(scl_fall));

  // R6
  write_at_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |-> stop_det);

  // R6
  busy_after_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |=> busy_o);

  // R6
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (run_cnt == WR_CYCLES));
endmodule

bind i2c_mem_slave i2c_mem_slave_chk #(.WR_CYCLES(WR_CYCLES)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .busy_o   (busy_o),
  .sda_oe_o (sda_oe_o),
  .scl_fall (scl_fall),
  .stop_det (stop_det),
  .mem_we   (mem_we)
);

// File: tb/i2c_mem_slave_test.sv
module i2c_mem_slave_test;
  localparam int CLK_P = 10;
  localparam int WR    = 1200;
  localparam int Q     = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic [2:0] dsel = 3'b101;
  logic [1:0] msize = 2'd1;
  logic sda_oe, busy, sda_line;

  assign sda_line = sda_m & ~sda_oe;

  i2c_mem_slave #(.WR_CYCLES(WR)) uut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_line),
    .sda_oe_o   (sda_oe),
    .dev_sel_i  (dsel),
    .mem_size_i (msize),
    .busy_o     (busy)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_run = 0, n_fail = 0;
  int busy_len = 0, busy_rises = 0, exp_rises = 0, quiet_viol = 0;
  bit quiet = 0, busy_prev = 0, done = 0;
  logic [7:0] ref_mem [1024];

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  // per-clock reference: busy window length and silence during lockout
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) busy_len++;
      else if (busy_len != 0) begin
        chk("R6", "busy window length", busy_len, WR);
        busy_len = 0;
      end
      if (busy && !busy_prev) busy_rises++;
      busy_prev = busy;
      if (quiet && sda_oe) quiet_viol++;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic bit exp_match(input logic [2:0] s);
    case (msize)
      2'd0, 2'd1: return s == dsel;
      2'd2:       return s[2:1] == dsel[2:1];
      default:    return s[2] == dsel[2];
    endcase
  endfunction

  function automatic int ref_addr(input logic [2:0] s, input logic [7:0] a);
    case (msize)
      2'd0:    return int'(a[6:0]);
      2'd1:    return int'(a);
      2'd2:    return int'({s[0], a});
      default: return int'({s[1:0], a});
    endcase
  endfunction

  task automatic bus_start();
    sda_m = 1; tick(Q); scl_m = 1; tick(Q); sda_m = 0; tick(Q); scl_m = 0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 0; tick(Q); scl_m = 1; tick(Q); sda_m = 1; tick(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      sda_m = b[i]; tick(Q); scl_m = 1; tick(2*Q); scl_m = 0; tick(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1; tick(Q); scl_m = 1; tick(Q);
    ack = ~sda_line;
    tick(Q); scl_m = 0; tick(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      scl_m = 1; tick(Q); b[i] = sda_line; tick(Q); scl_m = 0; tick(Q);
    end
    sda_m = 1; scl_m = 1; tick(2*Q); scl_m = 0; tick(Q);
  endtask

  task automatic do_write(input logic [2:0] s, input logic [7:0] a, input logic [7:0] d,
                          input bit fin, input string req);
    bit ack, m;
    m = exp_match(s);
    bus_start();
    send_byte({4'b1010, s, 1'b0}, ack); chk(req, "device ack", ack, m);
    send_byte(a, ack);                  chk(req, "address ack", ack, m);
    send_byte(d, ack);                  chk(req, "data ack", ack, m);
    if (fin) begin
      bus_stop();
      if (m) begin
        ref_mem[ref_addr(s, a)] = d;
        exp_rises++;
        tick(6);
        chk("R6", "busy after stop", busy, 1);
      end
    end
  endtask

  task automatic wait_idle();
    tick(4);
    while (busy) tick(1);
    tick(4);
  endtask

  task automatic check_read(input logic [2:0] s, input logic [7:0] a, input string req);
    bit ack;
    logic [7:0] d;
    bus_start();
    send_byte({4'b1010, s, 1'b0}, ack); chk(req, "read setup ack", ack, 1);
    send_byte(a, ack);                  chk(req, "read address ack", ack, 1);
    bus_start();
    send_byte({4'b1010, s, 1'b1}, ack); chk(req, "read device ack", ack, 1);
    recv_byte(d);
    chk(req, "read data", d, ref_mem[ref_addr(s, a)]);
    chk("R8", "sda released after byte", sda_oe, 0);
    bus_stop();
    tick(4);
  endtask

  initial begin
    bit ack;
    for (int i = 0; i < 1024; i++) ref_mem[i] = 8'h00;
    tick(3);
    chk("R1", "busy in reset", busy, 0);
    chk("R1", "oe in reset", sda_oe, 0);
    rst_n = 1;
    tick(5);
    chk("R1", "busy after reset", busy, 0);
    chk("R1", "oe after reset", sda_oe, 0);

    // R2 R3 R6 R8: basic write, 2 Kbit
    msize = 2'd1;
    do_write(3'b101, 8'h3C, 8'hA5, 1, "R3");
    wait_idle();
    check_read(3'b101, 8'h3C, "R8");

    // R2: strap mismatch gets no ack
    do_write(3'b100, 8'h3C, 8'h11, 1, "R2");
    tick(8);
    chk("R2", "no busy after rejected write", busy_rises, exp_rises);
    // R2: wrong prefix
    bus_start(); send_byte(8'b1011_1010, ack); chk("R2", "bad prefix ack", ack, 0); bus_stop();

    // R4: 4 Kbit, S0 is address bit 8
    msize = 2'd2;
    do_write(3'b100, 8'h10, 8'h5A, 1, "R4");
    wait_idle();
    check_read(3'b101, 8'h10, "R4");
    check_read(3'b100, 8'h10, "R4");
    do_write(3'b111, 8'h10, 8'h66, 1, "R4");
    tick(8);

    // R5: 8 Kbit, S1,S0 are address bits 9,8
    msize = 2'd3;
    do_write(3'b110, 8'h20, 8'hC3, 1, "R5");
    wait_idle();
    check_read(3'b100, 8'h20, "R5");
    check_read(3'b110, 8'h20, "R5");
    do_write(3'b010, 8'h20, 8'h99, 1, "R5");
    tick(8);

    // R7: repeated start instead of stop
    msize = 2'd1;
    do_write(3'b101, 8'h40, 8'h77, 0, "R7");
    check_read(3'b101, 8'h40, "R7");
    chk("R7", "no write cycle", busy_rises, exp_rises);

    // R9: stop after four data bits
    bus_start();
    send_byte({4'b1010, 3'b101, 1'b0}, ack); chk("R9", "device ack", ack, 1);
    send_byte(8'h41, ack);                   chk("R9", "address ack", ack, 1);
    send_bits(8'hE7, 4);
    bus_stop();
    tick(8);
    chk("R9", "no write cycle", busy_rises, exp_rises);
    check_read(3'b101, 8'h41, "R9");

    // R10: full write attempt right after a committing stop
    do_write(3'b101, 8'h50, 8'h11, 1, "R6");
    quiet = 1;
    bus_start();
    send_byte({4'b1010, 3'b101, 1'b0}, ack); chk("R10", "device ack while busy", ack, 0);
    send_byte(8'h51, ack);                   chk("R10", "address ack while busy", ack, 0);
    send_byte(8'h22, ack);                   chk("R10", "data ack while busy", ack, 0);
    bus_stop();
    chk("R10", "still busy after attempt", busy, 1);
    quiet = 0;
    wait_idle();
    chk("R10", "oe during lockout", quiet_viol, 0);
    check_read(3'b101, 8'h51, "R10");
    check_read(3'b101, 8'h50, "R10");

    // R11: 1 Kbit drops byte address bit 7
    msize = 2'd0;
    do_write(3'b101, 8'h85, 8'h9E, 1, "R11");
    wait_idle();
    msize = 2'd1;
    check_read(3'b101, 8'h05, "R11");
    check_read(3'b101, 8'h85, "R11");

    chk("R6", "write cycle count", busy_rises, exp_rises);
    finish_run();
  end
endmodule